// File: doc/BRIEF.md
# Tone Bus Receive Silence Timer and Interrupt Flags

This block sits behind the bit demodulator of a two-level tone signalling bus receiver. It takes one strobe per received bit, one strobe per completed byte and a 1 ms timebase tick. From these it times how long the bus has been quiet and raises three sticky interrupt flags: byte received, message ended and long silence. A message is taken to have ended when the bus has been quiet for about 6 ms after a byte. Reception never pauses, so a new message can start while the host is still handling the previous one.

The host reads an 8-bit interrupt word, and a read strobe clears every flag in it. An event that arrives in the same cycle as the read still sets its flag. A separate 8-bit status word shows a coarse silence counter in 16 ms units and the receive state for debugging.

Top module: `tone_bus_idle_irq`

## Requirements
- R1: In the cycle after `rx_byte` is sampled high, bit 0 of `irq_reg` (byte received) reads 1.
- R2: Bit 1 of `irq_reg` (message ended) reads 1 in the cycle after the 6th `ms_tick` that follows a byte with no `rx_bit` and no `rx_byte` in between. A tick that comes in the same cycle as a bit restarts the count. The flag is raised only once for each message.
- R3: Bit 1 of `irq_reg` is never raised by silence unless at least one byte has arrived since the previous message end.
- R4: A flag that is set stays set until a cycle with `irq_rd` high. In the cycle after that read, the flag reads 0 unless a new event arrived with the read.
- R5: If a flag's event arrives in the same cycle as `irq_rd`, the flag reads 1 after that cycle.
- R6: `status_reg[4:0]` equals floor(n/16), where n is the number of `ms_tick` pulses since the last `rx_bit` (or since reset). It returns to 0 in the cycle after a bit, and a bit arriving with a tick wins.
- R7: `status_reg[4:0]` saturates at 31 and holds 31 for any silence of 496 ticks or more.
- R8: Bit 3 of `irq_reg` (long silence) is set when the silence counter steps from 10 to 11, which is at the 176th tick.
- R9: After reset, `irq_reg` and `status_reg` are both 0x00. `irq_reg` bits 2 and 7:4 always read 0.
- R10: `status_reg[7:5]` holds the receive state. The codes are 0 for idle since reset, 1 for bits arriving with no byte completed, 2 for a byte completed and waiting for silence, and 3 for message ended.
- R11: Reception continues after a message end. A new byte sets bit 0 and moves the state to 2 while bit 1 is still set, and a later 6-tick silence raises bit 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| rx_bit | input | 1 | One-cycle pulse per received bit |
| rx_byte | input | 1 | One-cycle pulse per completed byte |
| irq_rd | input | 1 | Host read of the interrupt word; clears the flags |
| irq_reg | output | 8 | Interrupt word: bit 0 byte, bit 1 message end, bit 3 long silence |
| status_reg | output | 8 | Bits 7:5 receive state, bits 4:0 silence in 16 ms units |

## Verification
The assertions take all inputs to be known one-cycle levels sampled at the clock edge. They allow `rx_byte` to arrive in the same cycle as the last bit of the byte or on its own, and they allow a tick to coincide with a bit, a byte or a read. The stimulus changes inputs only a short time after each rising edge and holds every strobe for exactly one cycle. Its sweeps keep any silence used for message-end checks well under 176 ticks, so the long-silence flag appears only where a check expects it.

// File: rtl/tbi_pkg.sv
package tbi_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_BITS  = 3'd1,
        RX_GAP   = 3'd2,
        RX_ENDED = 3'd3
    } rx_state_e;

    typedef struct packed {
        logic byte_done;
        logic msg_end;
        logic long_quiet;
    } irq_events_t;

    localparam int IRQ_BYTE_POS = 0;
    localparam int IRQ_EOM_POS  = 1;
    localparam int IRQ_LONG_POS = 3;

    function automatic logic [7:0] irq_word(input irq_events_t f);
        logic [7:0] w;
        w = 8'h00;
        w[IRQ_BYTE_POS] = f.byte_done;
        w[IRQ_EOM_POS]  = f.msg_end;
        w[IRQ_LONG_POS] = f.long_quiet;
        return w;
    endfunction

endpackage

// File: rtl/silence_timer.sv
module silence_timer #(
    parameter int TICKS_PER_UNIT = 16,
    parameter int CNT_W          = 5,
    parameter int LONG_UNITS     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bit_stb,
    output logic [CNT_W-1:0] sil_cnt,
    output logic             long_ev
);
    localparam int SUB_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_UNIT - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] LONG_PRE = CNT_W'(LONG_UNITS - 1);
    localparam logic [CNT_W-1:0] LONG_HIT = CNT_W'(LONG_UNITS);

    logic [SUB_W-1:0] sub_cnt;
    logic [CNT_W-1:0] cnt;
    logic             unit_wrap;

    assign unit_wrap = tick && (sub_cnt == SUB_LAST);
    assign long_ev   = !bit_stb && unit_wrap && (cnt == LONG_PRE);
    assign sil_cnt   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_cnt <= '0;
            cnt     <= '0;
        end else if (bit_stb) begin
            sub_cnt <= '0;
            cnt     <= '0;
        end else if (tick) begin
            if (unit_wrap) begin
                sub_cnt <= '0;
                cnt     <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end

    // R6
    bit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> (cnt == '0) && (sub_cnt == '0));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) && !bit_stb |=> cnt == CNT_MAX);

    // R8
    long_event_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == LONG_HIT) && ($past(cnt) == LONG_PRE) |-> $past(long_ev));

endmodule

// File: rtl/eom_detector.sv
module eom_detector
    import tbi_pkg::*;
#(
    parameter int EOM_TICKS = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      bit_stb,
    input  logic      byte_stb,
    output logic      eom_ev,
    output rx_state_e state
);
    localparam int GAP_W = $clog2(EOM_TICKS + 1);
    localparam logic [GAP_W-1:0] GAP_PRE = GAP_W'(EOM_TICKS - 1);
    localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(EOM_TICKS);

    logic [GAP_W-1:0] gap;
    logic             pending;
    logic             activity;
    logic             quiet_tick;

    assign activity   = bit_stb || byte_stb;
    assign quiet_tick = tick && !activity;
    assign eom_ev     = pending && quiet_tick && (gap == GAP_PRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            pending <= 1'b0;
            state   <= RX_IDLE;
        end else begin
            if (activity)
                gap <= '0;
            else if (tick && gap != GAP_TOP)
                gap <= gap + 1'b1;

            if (byte_stb)
                pending <= 1'b1;
            else if (eom_ev)
                pending <= 1'b0;

            if (byte_stb)
                state <= RX_GAP;
            else if (bit_stb)
                state <= RX_BITS;
            else if (eom_ev)
                state <= RX_ENDED;
        end
    end

    // R2
    eom_once_chk: assert property (@(posedge clk) disable iff (rst)
        eom_ev |=> (state == RX_ENDED) && !pending);

    // R3
    ended_not_armed_chk: assert property (@(posedge clk) disable iff (rst)
        state == RX_ENDED |-> !pending);

    // R10
    byte_state_chk: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> state == RX_GAP);

endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import tbi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  irq_events_t ev,
    input  logic        rd,
    output logic [7:0]  irq_reg
);
    irq_events_t flags;

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (rd ? irq_events_t'('0) : flags) | ev;
    end

    assign irq_reg = irq_word(flags);

    // R1
    byte_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ev.byte_done |=> irq_reg[IRQ_BYTE_POS]);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        irq_reg[IRQ_EOM_POS] && !rd |=> irq_reg[IRQ_EOM_POS]);

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd && (ev == '0) |=> irq_reg == 8'h00);

    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rd && ev.msg_end |=> irq_reg[IRQ_EOM_POS]);

    // R9
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_reg & 8'hF4) == 8'h00);

endmodule

// File: rtl/tone_bus_idle_irq.sv
module tone_bus_idle_irq
    import tbi_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 16,
    parameter int EOM_TICKS      = 6,
    parameter int LONG_UNITS     = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic       rx_bit,
    input  logic       rx_byte,
    input  logic       irq_rd,
    output logic [7:0] irq_reg,
    output logic [7:0] status_reg
);
    localparam int STATE_W = $bits(rx_state_e);
    localparam int CNT_W   = 8 - STATE_W;

    logic [CNT_W-1:0] sil_cnt;
    logic             long_ev;
    logic             eom_ev;
    rx_state_e        state;
    irq_events_t      events;

    silence_timer #(
        .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .CNT_W         (CNT_W),
        .LONG_UNITS    (LONG_UNITS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (ms_tick),
        .bit_stb(rx_bit),
        .sil_cnt(sil_cnt),
        .long_ev(long_ev)
    );

    eom_detector #(
        .EOM_TICKS(EOM_TICKS)
    ) u_eom (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .bit_stb (rx_bit),
        .byte_stb(rx_byte),
        .eom_ev  (eom_ev),
        .state   (state)
    );

    always_comb begin
        events.byte_done  = rx_byte;
        events.msg_end    = eom_ev;
        events.long_quiet = long_ev;
    end

    irq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .ev     (events),
        .rd     (irq_rd),
        .irq_reg(irq_reg)
    );

    assign status_reg = {state, sil_cnt};

endmodule

// File: tb/tone_bus_idle_irq_test.sv
`timescale 1ns/1ps
module tone_bus_idle_irq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_byte = 1'b0;
    logic       irq_rd = 1'b0;
    logic [7:0] irq_reg;
    logic [7:0] status_reg;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tone_bus_idle_irq uut (
        .clk       (clk),
        .rst       (rst),
        .ms_tick   (ms_tick),
        .rx_bit    (rx_bit),
        .rx_byte   (rx_byte),
        .irq_rd    (irq_rd),
        .irq_reg   (irq_reg),
        .status_reg(status_reg)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic t, input logic b, input logic y, input logic r);
        ms_tick = t; rx_bit = b; rx_byte = y; irq_rd = r;
        @(posedge clk);
        #2;
        ms_tick = 0; rx_bit = 0; rx_byte = 0; irq_rd = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R9 reset state
        check("R9 irq reset", irq_reg, 8'h00);
        check("R9 status reset", status_reg, 8'h00);

        // R6 R7 R8 R10 silence sweep after a lone bit
        cyc(0, 1, 0, 0);
        check("R10 bits state", status_reg, {3'd1, 5'd0});
        cyc(0, 0, 0, 1);
        for (int n = 1; n <= 520; n++) begin
            int e;
            cyc(1, 0, 0, 0);
            e = n / 16;
            if (e > 31) e = 31;
            check("R6 R7 silence count", status_reg, {3'd1, 5'(e)});
            check("R8 long silence flag", irq_reg, (n >= 176) ? 8'h08 : 8'h00);
        end
        cyc(1, 1, 0, 0);
        check("R6 bit beats tick", status_reg, {3'd1, 5'd0});
        check("R4 long flag sticky", irq_reg, 8'h08);
        cyc(0, 0, 0, 1);
        check("R4 read clears", irq_reg, 8'h00);

        // R1 R2 R10 basic message end
        cyc(0, 1, 1, 0);
        check("R1 byte flag", irq_reg, 8'h01);
        check("R10 gap state", status_reg, {3'd2, 5'd0});
        for (int n = 1; n <= 10; n++) begin
            cyc(1, 0, 0, 0);
            check("R2 eom timing", irq_reg, (n >= 6) ? 8'h03 : 8'h01);
            check("R10 state after gap", status_reg[7:5], (n >= 6) ? 8'd3 : 8'd2);
        end
        cyc(0, 0, 0, 1);
        check("R4 read clears both", irq_reg, 8'h00);
        for (int n = 1; n <= 10; n++) begin
            cyc(1, 0, 0, 0);
            check("R2 eom once", irq_reg, 8'h00);
        end

        // R2 gap sweep: byte, k ticks, then a bit continues the message
        for (int k = 1; k <= 9; k++) begin
            cyc(0, 0, 0, 1);
            cyc(0, 1, 1, 0);
            ticks(k);
            check("R2 gap sweep", irq_reg, (k >= 6) ? 8'h03 : 8'h01);
            cyc(0, 1, 0, 0);
            cyc(0, 0, 0, 1);
            ticks(6);
            check("R2 R3 after bit", irq_reg, (k < 6) ? 8'h02 : 8'h00);
        end

        // R2 tick with bit restarts count
        cyc(0, 0, 0, 1);
        cyc(0, 1, 1, 0);
        ticks(5);
        cyc(1, 1, 0, 0);
        check("R2 bit restarts", irq_reg, 8'h01);
        ticks(5);
        check("R2 five after restart", irq_reg, 8'h01);
        ticks(1);
        check("R2 sixth after restart", irq_reg, 8'h03);

        // R3 bits without byte after a message end
        cyc(0, 0, 0, 1);
        cyc(0, 1, 0, 0);
        ticks(10);
        check("R3 no byte no eom", irq_reg, 8'h00);
        check("R3 state bits", status_reg[7:5], 8'd1);

        // R5 collisions
        cyc(0, 1, 1, 0);
        cyc(0, 1, 1, 1);
        check("R5 byte with read", irq_reg, 8'h01);
        cyc(0, 0, 0, 1);
        check("R5 then cleared", irq_reg, 8'h00);
        ticks(5);
        cyc(1, 0, 0, 1);
        check("R5 eom with read", irq_reg, 8'h02);
        repeat (40) cyc(0, 0, 0, 0);
        check("R4 held without read", irq_reg, 8'h02);

        // R11 new message while eom still set
        cyc(0, 1, 1, 0);
        check("R11 byte during eom", irq_reg, 8'h03);
        check("R11 state", status_reg[7:5], 8'd2);
        cyc(0, 0, 0, 1);
        ticks(6);
        check("R11 second eom", irq_reg, 8'h02);
        check("R11 ended state", status_reg[7:5], 8'd3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule